// File: doc/BRIEF.md
# USB Host Controller Bring-up and Interrupt Sequencer

This block is a control state machine that drives an external USB host controller through a register access port. Each access on that port is one SPI transaction of two bytes. After a start request, the sequencer first sets the controller's pin behaviour and pulses its chip reset. It then polls the oscillator-ready flag, with a programmable wait between attempts and a bounded number of attempts. When the flag is seen, it writes the host-mode configuration and the interrupt enables. If the flag never appears, it reports failure.

Once configured, the sequencer watches the controller's level-sensitive interrupt line. While the line is high, it may read the bus line-state register and keep the value. It then writes back a chosen subset of the pending flags to clear them. The access port returns a status byte with every access, and that byte steers these decisions. USB enumeration and data transfers belong to other logic.

Top module: `usbh_bringup_seq`

## Requirements
- R1: After reset `req_o`, `ready_o` and `fail_o` are 0 and `line_status_o` is 0x00. No access is requested until `start_i` is seen.
- R2: Once `req_o` rises, it stays high with `we_o`, `addr_o` and `wdata_o` unchanged until the cycle in which `done_i` is high. Each step issues exactly one access. `status_i` is captured as the last status on every completed access.
- R3: After start, the first three accesses are writes, in this order: register 17 with 0x18, then register 15 with 0x20, then register 15 with 0x00.
- R4: Oscillator-ready is tested by a read of register 13. The test passes when (`rdata_i` & 0x9F) == 0x01, so bits 5 and 6 of the read value are ignored.
- R5: After a failed test, the sequencer waits exactly PRESCALE*WAIT_TICKS cycles and then issues the next read of register 13. When the NUM_TRIES-th test fails, `fail_o` goes high and no further access is issued.
- R6: After a passing test, the sequencer writes register 27 with 0xC1, then register 16 with 0x01, then register 26 with 0x20. It then holds `ready_o` high.
- R7: While `ready_o` is high and `int_i` is low, no access is requested. When `int_i` is high, one service is performed.
- R8: A service starts with a read of register 31 if the last status has bit 4 or bit 5 set. That read loads `rdata_i` into `line_status_o`. The service always ends with a write to register 25 of the last status ANDed with 0x19. If the service included the line read, the last status used here is the one returned by that read.
- R9: `start_i` is ignored during bring-up and while ready. In the failed state, `start_i` clears `fail_o` and restarts the whole sequence from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the bring-up sequence |
| int_i | input | 1 | Controller interrupt line, level-sensitive, active high |
| req_o | output | 1 | Access request, held until done |
| we_o | output | 1 | 1 = register write, 0 = register read |
| addr_o | output | 5 | Register number |
| wdata_o | output | 8 | Write value |
| done_i | input | 1 | Access complete, one-cycle pulse |
| status_i | input | 8 | Status byte returned by the access, valid with done |
| rdata_i | input | 8 | Read value, valid with done |
| ready_o | output | 1 | Bring-up complete, servicing interrupts |
| fail_o | output | 1 | Oscillator never became ready |
| line_status_o | output | 8 | Last value read from the line-state register |

## Verification
The assertions assume that `done_i` pulses for a single cycle, and only while `req_o` is high. They also assume that `status_i` and `rdata_i` are valid in that same cycle. The bench's port model accepts a request, waits one to three cycles, and answers with one `done_i` pulse. It never raises `done_i` unasked, and it drives all inputs on the falling edge. The interrupt line is raised only by the bench, and the model drops it when it sees the write to register 25. Status bytes are random, with short stretches forced to have bits 4 and 5 set or clear so that both service paths are reached.

// File: rtl/usbh_bup_pkg.sv
package usbh_bup_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] REG_OSC_IRQ  = 5'd13;
  localparam logic [ADDR_W-1:0] REG_USB_CTL  = 5'd15;
  localparam logic [ADDR_W-1:0] REG_CPU_CTL  = 5'd16;
  localparam logic [ADDR_W-1:0] REG_PIN_CTL  = 5'd17;
  localparam logic [ADDR_W-1:0] REG_HOST_IRQ = 5'd25;
  localparam logic [ADDR_W-1:0] REG_HOST_IEN = 5'd26;
  localparam logic [ADDR_W-1:0] REG_MODE     = 5'd27;
  localparam logic [ADDR_W-1:0] REG_LINE     = 5'd31;

  localparam logic [DATA_W-1:0] VAL_PIN_CFG  = 8'h18;
  localparam logic [DATA_W-1:0] VAL_RST_SET  = 8'h20;
  localparam logic [DATA_W-1:0] VAL_RST_CLR  = 8'h00;
  localparam logic [DATA_W-1:0] VAL_MODE     = 8'hC1;
  localparam logic [DATA_W-1:0] VAL_CPU_IE   = 8'h01;
  localparam logic [DATA_W-1:0] VAL_HOST_IEN = 8'h20;

  localparam logic [DATA_W-1:0] OSC_IGNORE   = 8'h60;
  localparam logic [DATA_W-1:0] OSC_READY    = 8'h01;
  localparam logic [DATA_W-1:0] LINE_TRIGGER = 8'h30;
  localparam logic [DATA_W-1:0] ACK_MASK     = 8'h19;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PIN,
    ST_RST_SET,
    ST_RST_CLR,
    ST_OSC,
    ST_WAIT,
    ST_MODE,
    ST_CPU,
    ST_IEN,
    ST_RUN,
    ST_LINE,
    ST_ACK,
    ST_FAIL
  } bup_state_e;

  typedef struct packed {
    logic              req;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } bus_op_t;

endpackage

// File: rtl/bup_wait_timer.sv
module bup_wait_timer #(
  parameter int unsigned PRESCALE   = 2,
  parameter int unsigned WAIT_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);

  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned TW = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;
  logic          pre_wrap;

  assign pre_wrap  = (pre_q == PW'(PRESCALE - 1));
  assign expired_o = en_i & pre_wrap & (tick_q == TW'(WAIT_TICKS - 1));

  // counters restart from zero on every entry to the wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (!en_i) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (pre_wrap) begin
      pre_q  <= '0;
      tick_q <= tick_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/bup_retry_cnt.sv
module bup_retry_cnt #(
  parameter int unsigned NUM_TRIES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned CW = $clog2(NUM_TRIES + 1);

  logic [CW-1:0] cnt_q;

  // high while the attempt in flight is the final permitted one
  assign last_o = (cnt_q == CW'(NUM_TRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bup_step_dec.sv
module bup_step_dec
  import usbh_bup_pkg::*;
(
  input  bup_state_e        state_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output bus_op_t           op_o
);

  always_comb begin
    op_o = '0;
    unique case (state_i)
      ST_PIN:     op_o = '{req: 1'b1, we: 1'b1, addr: REG_PIN_CTL,  wdata: VAL_PIN_CFG};
      ST_RST_SET: op_o = '{req: 1'b1, we: 1'b1, addr: REG_USB_CTL,  wdata: VAL_RST_SET};
      ST_RST_CLR: op_o = '{req: 1'b1, we: 1'b1, addr: REG_USB_CTL,  wdata: VAL_RST_CLR};
      ST_OSC:     op_o = '{req: 1'b1, we: 1'b0, addr: REG_OSC_IRQ,  wdata: '0};
      ST_MODE:    op_o = '{req: 1'b1, we: 1'b1, addr: REG_MODE,     wdata: VAL_MODE};
      ST_CPU:     op_o = '{req: 1'b1, we: 1'b1, addr: REG_CPU_CTL,  wdata: VAL_CPU_IE};
      ST_IEN:     op_o = '{req: 1'b1, we: 1'b1, addr: REG_HOST_IEN, wdata: VAL_HOST_IEN};
      ST_LINE:    op_o = '{req: 1'b1, we: 1'b0, addr: REG_LINE,     wdata: '0};
      ST_ACK:     op_o = '{req: 1'b1, we: 1'b1, addr: REG_HOST_IRQ, wdata: ack_data_i};
      default:    op_o = '0;
    endcase
  end

endmodule

// File: rtl/usbh_bringup_seq.sv
module usbh_bringup_seq
  import usbh_bup_pkg::*;
#(
  parameter int unsigned NUM_TRIES  = 1024,
  parameter int unsigned PRESCALE   = 250,
  parameter int unsigned WAIT_TICKS = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              int_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ready_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] line_status_o
);

  bup_state_e        state_q, state_d;
  bus_op_t           op;
  logic              acc_done;
  logic              osc_ok;
  logic              start_ok;
  logic              wait_exp;
  logic              last_try;
  logic              osc_fail;
  logic [DATA_W-1:0] last_stat_q;
  logic [DATA_W-1:0] line_q;
  logic [DATA_W-1:0] ack_data;

  assign acc_done = op.req & done_i;
  assign osc_ok   = ((rdata_i & ~OSC_IGNORE) == OSC_READY);
  assign start_ok = start_i & ((state_q == ST_IDLE) | (state_q == ST_FAIL));
  assign osc_fail = (state_q == ST_OSC) & done_i & ~osc_ok;
  assign ack_data = last_stat_q & ACK_MASK;

  bup_step_dec i_step_dec (
    .state_i    (state_q),
    .ack_data_i (ack_data),
    .op_o       (op)
  );

  bup_wait_timer #(
    .PRESCALE   (PRESCALE),
    .WAIT_TICKS (WAIT_TICKS)
  ) i_wait_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ST_WAIT),
    .expired_o (wait_exp)
  );

  bup_retry_cnt #(
    .NUM_TRIES (NUM_TRIES)
  ) i_retry_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .inc_i  (osc_fail),
    .last_o (last_try)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FAIL: if (start_ok) state_d = ST_PIN;
      ST_PIN:     if (acc_done) state_d = ST_RST_SET;
      ST_RST_SET: if (acc_done) state_d = ST_RST_CLR;
      ST_RST_CLR: if (acc_done) state_d = ST_OSC;
      ST_OSC: begin
        if (acc_done) begin
          if (osc_ok)        state_d = ST_MODE;
          else if (last_try) state_d = ST_FAIL;
          else               state_d = ST_WAIT;
        end
      end
      ST_WAIT:    if (wait_exp) state_d = ST_OSC;
      ST_MODE:    if (acc_done) state_d = ST_CPU;
      ST_CPU:     if (acc_done) state_d = ST_IEN;
      ST_IEN:     if (acc_done) state_d = ST_RUN;
      ST_RUN: begin
        if (int_i) state_d = ((last_stat_q & LINE_TRIGGER) != '0) ? ST_LINE : ST_ACK;
      end
      ST_LINE:    if (acc_done) state_d = ST_ACK;
      ST_ACK:     if (acc_done) state_d = ST_RUN;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_stat_q <= '0;
    else if (acc_done) last_stat_q <= status_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             line_q <= '0;
    else if (acc_done && state_q == ST_LINE) line_q <= rdata_i;
  end

  assign req_o         = op.req;
  assign we_o          = op.we;
  assign addr_o        = op.addr;
  assign wdata_o       = op.wdata;
  assign ready_o       = (state_q == ST_RUN) | (state_q == ST_LINE) | (state_q == ST_ACK);
  assign fail_o        = (state_q == ST_FAIL);
  assign line_status_o = line_q;

endmodule

// File: rtl/usbh_bringup_seq_chk.sv
module usbh_bringup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       int_i,
  input logic       req_o,
  input logic       we_o,
  input logic [4:0] addr_o,
  input logic [7:0] wdata_o,
  input logic       done_i,
  input logic       ready_o,
  input logic       fail_o,
  input logic [7:0] line_status_o
);

  // R1
  ready_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && fail_o));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=> (req_o && $stable(we_o) && $stable(addr_o) && $stable(wdata_o)));

  // R5
  fail_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !req_o);

  // R5
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o);

  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // R7
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !req_o && !int_i) |=> !req_o);

  // R8
  ack_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o && addr_o == 5'd25) |-> ((wdata_o & 8'hE6) == 8'h00));

  // R8
  line_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && done_i && !we_o && addr_o == 5'd31) |=> $stable(line_status_o));

endmodule

bind usbh_bringup_seq usbh_bringup_seq_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .int_i         (int_i),
  .req_o         (req_o),
  .we_o          (we_o),
  .addr_o        (addr_o),
  .wdata_o       (wdata_o),
  .done_i        (done_i),
  .ready_o       (ready_o),
  .fail_o        (fail_o),
  .line_status_o (line_status_o)
);

// File: tb/test_usbh_bringup_seq.sv
module test_usbh_bringup_seq;

  localparam int unsigned TRIES = 4;
  localparam int unsigned PRE   = 3;
  localparam int unsigned TICKS = 5;
  localparam int unsigned GAP   = PRE * TICKS + 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       int_i;
  logic       req_o, we_o, ready_o, fail_o;
  logic [4:0] addr_o;
  logic [7:0] wdata_o, line_status_o;
  logic       done_i = 1'b0;
  logic [7:0] status_i = '0;
  logic [7:0] rdata_i = '0;

  always #2 clk_i = ~clk_i;

  usbh_bringup_seq #(
    .NUM_TRIES  (TRIES),
    .PRESCALE   (PRE),
    .WAIT_TICKS (TICKS)
  ) i_usbh_bringup_seq (
    .clk_i, .rst_ni, .start_i, .int_i, .req_o, .we_o, .addr_o, .wdata_o,
    .done_i, .status_i, .rdata_i, .ready_o, .fail_o, .line_status_o
  );

  // access log filled by the port model
  logic       log_we   [256];
  logic [4:0] log_addr [256];
  logic [7:0] log_data [256];
  logic [7:0] log_stat [256];
  logic [7:0] log_rd   [256];
  int         log_n = 0;

  int  checks = 0, failures = 0;
  int  m_checks = 0, m_fails = 0;
  int  cyc = 0;
  int  osc_cnt = 0, osc_base = 0, osc_fail_cfg = 0;
  int  stat_force = 0;
  int  irq_req_cnt = 0, irq_ack_cnt = 0;

  assign int_i = (irq_req_cnt != irq_ack_cnt);

  // port model state
  logic m_busy = 1'b0;
  int   m_lat = 0;
  int   m_cur = 0;
  int   fail_done_cyc = 0;
  logic gap_armed = 1'b0;

  always @(negedge clk_i) begin
    cyc = cyc + 1;
    if (!rst_ni) begin
      done_i = 1'b0; m_busy = 1'b0; gap_armed = 1'b0;
    end else if (done_i) begin
      done_i = 1'b0;
      m_busy = 1'b0;
    end else if (!m_busy && req_o) begin
      m_cur = log_n;
      log_we[m_cur] = we_o; log_addr[m_cur] = addr_o; log_data[m_cur] = wdata_o;
      log_n = log_n + 1;
      if (!we_o && addr_o == 5'd13) begin
        if (gap_armed) begin
          m_checks = m_checks + 1;
          if (cyc - fail_done_cyc != GAP) begin
            m_fails = m_fails + 1;
            $display("FAIL R5 retry gap actual=%0d expected=%0d", cyc - fail_done_cyc, GAP);
          end
        end
      end
      gap_armed = 1'b0;
      m_lat = $urandom_range(2, 0);
      m_busy = 1'b1;
    end else if (m_busy) begin
      if (m_lat > 0) m_lat = m_lat - 1;
      else begin
        // R2: request held steady until completion
        m_checks = m_checks + 1;
        if (!req_o || we_o != log_we[m_cur] || addr_o != log_addr[m_cur] || wdata_o != log_data[m_cur]) begin
          m_fails = m_fails + 1;
          $display("FAIL R2 request changed actual=%0d/%0d/%h expected=%0d/%0d/%h",
                   we_o, addr_o, wdata_o, log_we[m_cur], log_addr[m_cur], log_data[m_cur]);
        end
        status_i = 8'($urandom);
        if (stat_force == 1) status_i = status_i | 8'h30;
        if (stat_force == 2) status_i = status_i & 8'hCF;
        rdata_i = 8'($urandom);
        if (!we_o && addr_o == 5'd13) begin
          if (osc_cnt - osc_base < osc_fail_cfg) begin
            if ((rdata_i & 8'h9F) == 8'h01) rdata_i = rdata_i | 8'h80;
            fail_done_cyc = cyc;
            gap_armed = 1'b1;
          end else begin
            rdata_i = 8'h01 | (rdata_i & 8'h60);
          end
          osc_cnt = osc_cnt + 1;
        end
        if (we_o && addr_o == 5'd25 && int_i) irq_ack_cnt = irq_ack_cnt + 1;
        log_stat[m_cur] = status_i;
        log_rd[m_cur] = rdata_i;
        done_i = 1'b1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks + 1, failures + m_fails + 1);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_acc(input int idx, input logic we, input logic [4:0] a, input logic [7:0] d, input string req);
    chk(log_we[idx] == we && log_addr[idx] == a, req, {log_we[idx], log_addr[idx]}, {we, a});
    if (we) chk(log_data[idx] == d, req, log_data[idx], d);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic check_bringup(input int base, input int fails, input string req);
    exp_acc(base + 0, 1'b1, 5'd17, 8'h18, "R3");
    exp_acc(base + 1, 1'b1, 5'd15, 8'h20, "R3");
    exp_acc(base + 2, 1'b1, 5'd15, 8'h00, "R3");
    for (int k = 0; k <= fails; k++) exp_acc(base + 3 + k, 1'b0, 5'd13, 8'h00, "R4");
    exp_acc(base + 4 + fails, 1'b1, 5'd27, 8'hC1, "R6");
    exp_acc(base + 5 + fails, 1'b1, 5'd16, 8'h01, "R6");
    exp_acc(base + 6 + fails, 1'b1, 5'd26, 8'h20, "R6");
    chk(log_n - base == 7 + fails, req, log_n - base, 7 + fails);
    chk(ready_o && !fail_o, "R6 ready", {ready_o, fail_o}, 2'b10);
  endtask

  initial begin
    int base, prior, exp_line;
    logic [7:0] pstat;
    process::self().srandom(32'h5EED_0042);
    cycles(3);
    // R1 reset state
    chk(!req_o && !ready_o && !fail_o && line_status_o == 8'h00, "R1 reset",
        {req_o, ready_o, fail_o, line_status_o}, 0);
    rst_ni = 1'b1;
    cycles(20);
    chk(log_n == 0 && !req_o, "R1 idle without start", log_n, 0);

    // bring-up with two failed oscillator tests, stray starts mid-run
    osc_base = osc_cnt; osc_fail_cfg = 2;
    base = log_n;
    pulse_start();
    cycles(4); pulse_start();
    cycles(12); pulse_start();
    while (!ready_o && !fail_o) @(negedge clk_i);
    cycles(4);
    check_bringup(base, 2, "R9 start ignored in bring-up");

    // start while ready
    base = log_n;
    pulse_start();
    cycles(30);
    chk(log_n == base && ready_o, "R9 start ignored when ready", log_n - base, 0);

    // interrupt service
    exp_line = 0;
    for (int i = 0; i < 24; i++) begin
      stat_force = (i < 2) ? 1 : (i < 4) ? 2 : 0;
      base = log_n;
      pstat = log_stat[base - 1];
      irq_req_cnt = irq_req_cnt + 1;
      while (irq_ack_cnt != irq_req_cnt) @(negedge clk_i);
      cycles(3);
      if ((pstat & 8'h30) != 0) begin
        exp_acc(base, 1'b0, 5'd31, 8'h00, "R8 line read");
        exp_acc(base + 1, 1'b1, 5'd25, log_stat[base] & 8'h19, "R8 ack after line read");
        exp_line = log_rd[base];
        chk(log_n - base == 2, "R8 access count", log_n - base, 2);
      end else begin
        exp_acc(base, 1'b1, 5'd25, pstat & 8'h19, "R8 ack only");
        chk(log_n - base == 1, "R8 access count", log_n - base, 1);
      end
      chk(line_status_o == 8'(exp_line), "R8 line status", line_status_o, exp_line);
      prior = log_n;
      cycles(8);
      chk(log_n == prior && ready_o, "R7 quiet while int low", log_n - prior, 0);
    end
    stat_force = 0;

    // failure path
    rst_ni = 1'b0; cycles(2);
    chk(!ready_o && !fail_o && line_status_o == 8'h00, "R1 reset again",
        {ready_o, fail_o, line_status_o}, 0);
    rst_ni = 1'b1; cycles(2);
    osc_base = osc_cnt; osc_fail_cfg = 100;
    base = log_n;
    pulse_start();
    while (!ready_o && !fail_o) @(negedge clk_i);
    chk(fail_o && !ready_o, "R5 fail flag", {fail_o, ready_o}, 2'b10);
    chk(log_n - base == 3 + TRIES, "R5 read attempts", log_n - base, 3 + TRIES);
    for (int k = 0; k < int'(TRIES); k++) exp_acc(base + 3 + k, 1'b0, 5'd13, 8'h00, "R5");
    prior = log_n;
    cycles(25);
    chk(log_n == prior && fail_o, "R5 no access after fail", log_n - prior, 0);

    // restart from failure
    osc_base = osc_cnt; osc_fail_cfg = 0;
    base = log_n;
    pulse_start();
    chk(!fail_o, "R9 start clears fail", fail_o, 0);
    while (!ready_o && !fail_o) @(negedge clk_i);
    cycles(4);
    check_bringup(base, 0, "R9 restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks, failures + m_fails);
    $finish;
  end

endmodule